// File: doc/BRIEF.md
# Word-Atomic I2C Register Target

This block is a target-only I2C interface that lets a bus host reach a bank of 64 registers, each 24 bits wide. It oversamples SCL and SDA with a fast system clock and finds START and STOP conditions on the resynchronised lines. It answers one 7-bit device address. The lowest address bit of that address comes from a board strap. The block pulls SDA low through an open-drain enable and never drives it high. On the other side it drives a plain register-file port: a single-cycle write strobe with index and word, and a read index with a combinational read word.

A write transfer has four parts: the address with R/W low, one index byte, then data in groups of three bytes, most significant first. The bytes gather in a staging buffer. The register is written only when the third byte's acknowledge begins. A transfer cut short by STOP or by a repeated START leaves the target register as it was. Further complete groups in the same transfer go to the following indices. A read sets the index with a short write, then sends a repeated START and the address with R/W high. It returns a snapshot of the indexed word as three bytes, as long as the host keeps acknowledging.

Top module: `i2cw_target`

## Requirements
- R1: After reset `sda_oe` is 0 and `reg_wr_en` is 0.
- R2: The block acknowledges only the 7-bit address {0,0,0,1,0,0,addr_strap}, i.e. 0x08 with the strap low and 0x09 with it high; any other address gets no acknowledge.
- R3: The general-call address 0x00 and any 10-bit header (top five bits 11110) get no acknowledge, and the block leaves SDA alone for all following bytes until the next START.
- R4: In a write, the byte after the address selects the register by its low 6 bits. Each group of three following bytes, MSB first, produces exactly one `reg_wr_en` pulse carrying the full word, issued while the third byte's acknowledge is being driven.
- R5: A STOP or repeated START before a group of three data bytes completes produces no write, and the partial bytes are discarded, so a later group starts afresh.
- R6: After a repeated START and the matching address with R/W high, the block returns the indexed register as three bytes, MSB first.
- R7: If the host answers a read byte with NACK (SDA high), the block releases SDA and drives nothing until the next START.
- R8: The block changes its SDA drive only while the synchronised SCL is low, and it never pulls SDA while the host is sending a bit.
- R9: The address byte when matched, the index byte and every write data byte each get an acknowledge (SDA low during the ninth clock).
- R10: Successive complete groups in one write transfer go to successive indices, wrapping from 63 to 0.
- R11: A STOP always returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_strap | input | 1 | Strap selecting device address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_idx | output | 6 | Register index for the write |
| reg_wr_data | output | 24 | Word to write |
| reg_rd_idx | output | 6 | Register index to read |
| reg_rd_data | input | 24 | Word at `reg_rd_idx`, combinational |

## Verification
The bench aims at partial writes cut off after zero, one and two data bytes, by STOP and by a repeated START. A design that commits early or keeps stale staged bytes would write a register it should leave alone, or would assemble a word out of two transfers. It writes across the 63-to-0 wrap, where a design with a wrong index width or a missed increment would put the second word in the wrong place. It sends the strap-selected address, the other strap value, general call and a 10-bit header; a loose address compare would acknowledge one of these or disturb the following bytes. It also cuts a read short with a NACK, after which a design that kept shifting would pull SDA low in the host's next clocks.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_AACK,
      S_IDX,
      S_IACK,
      S_WDAT,
      S_WACK,
      S_RDAT,
      S_RMACK,
      S_IGNORE
   } i2cw_state_e;

   function automatic logic addr_hit(input logic [6:0] rx_addr,
                                     input logic [5:0] fixed_hi,
                                     input logic       strap);
      return rx_addr == {fixed_hi, strap};
   endfunction

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_d;
   logic              sda_d;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cw_line_sync: STAGES must be at least 2");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain[0] <= 1'b1;
               sda_chain[0] <= 1'b1;
            end else begin
               scl_chain[0] <= scl_i;
               sda_chain[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain[k] <= 1'b1;
               sda_chain[k] <= 1'b1;
            end else begin
               scl_chain[k] <= scl_chain[k-1];
               sda_chain[k] <= sda_chain[k-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_chain[STAGES-1];
         sda_d <= sda_chain[STAGES-1];
      end
   end

   assign scl_s     = scl_chain[STAGES-1];
   assign sda_s     = sda_chain[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cw_word_stage.sv
module i2cw_word_stage #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              byte_valid,
   input  logic [7:0]        byte_in,
   output logic              commit,
   output logic [WORD_W-1:0] word
);

   localparam int NB = WORD_W / 8;
   localparam int CW = (NB > 2) ? $clog2(NB) : 1;

   if (WORD_W % 8 != 0 || NB < 2) begin : g_bad_width
      $error("i2cw_word_stage: WORD_W must be a multiple of 8, at least 16");
   end

   logic [WORD_W-9:0] stage_q;
   logic [CW-1:0]     cnt_q;
   logic [WORD_W-1:0] joined;

   assign joined = {stage_q, byte_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         cnt_q   <= '0;
         commit  <= 1'b0;
         word    <= '0;
      end else begin
         commit <= 1'b0;
         if (clear) begin
            stage_q <= '0;
            cnt_q   <= '0;
         end else if (byte_valid) begin
            if (cnt_q == CW'(NB - 1)) begin
               word    <= joined;
               commit  <= 1'b1;
               cnt_q   <= '0;
               stage_q <= '0;
            end else begin
               stage_q <= joined[WORD_W-9:0];
               cnt_q   <= cnt_q + 1'b1;
            end
         end
      end
   end

   a_r5_stage_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(NB - 1));

   a_r4_single_commit : assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

endmodule

// File: rtl/i2cw_read_feed.sv
module i2cw_read_feed #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              advance,
   output logic [7:0]        cur_byte,
   output logic              next_msb,
   output logic              last
);

   localparam int NB = WORD_W / 8;
   localparam int CW = (NB > 2) ? $clog2(NB) : 1;

   if (WORD_W % 8 != 0 || NB < 2) begin : g_bad_width
      $error("i2cw_read_feed: WORD_W must be a multiple of 8, at least 16");
   end

   logic [WORD_W-1:0] data_q;
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         data_q <= word_in;
         cnt_q  <= '0;
      end else if (advance) begin
         data_q <= {data_q[WORD_W-9:0], 8'h00};
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cur_byte = data_q[WORD_W-1 -: 8];
   assign next_msb = data_q[WORD_W-9];
   assign last     = (cnt_q == CW'(NB - 1));

   a_r6_feed_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(NB - 1));

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target #(
   parameter int         IDX_W       = 6,
   parameter int         WORD_W      = 24,
   parameter int         SYNC_STAGES = 2,
   parameter logic [5:0] ADDR_FIXED  = 6'b000100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_strap,
   output logic              sda_oe,
   output logic              reg_wr_en,
   output logic [IDX_W-1:0]  reg_wr_idx,
   output logic [WORD_W-1:0] reg_wr_data,
   output logic [IDX_W-1:0]  reg_rd_idx,
   input  logic [WORD_W-1:0] reg_rd_data
);
   import i2cw_pkg::*;

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("i2cw_target: IDX_W must be 1..8");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic no_evt;

   i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   assign no_evt = ~start_det & ~stop_det;

   i2cw_state_e      state_q;
   logic [2:0]       bitcnt_q;
   logic [7:0]       shreg_q;
   logic             byte_full_q;
   logic             rw_q;
   logic             ack_q;
   logic             oe_q;
   logic [IDX_W-1:0] idx_q;

   logic             stage_valid, stage_commit;
   logic [WORD_W-1:0] stage_word;
   logic             feed_load, feed_adv, feed_next_msb, feed_last;
   logic [7:0]       feed_byte;

   assign stage_valid = (state_q == S_WDAT) & scl_fall & byte_full_q & no_evt;

   i2cw_word_stage #(.WORD_W(WORD_W)) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start_det | stop_det),
      .byte_valid (stage_valid),
      .byte_in    (shreg_q),
      .commit     (stage_commit),
      .word       (stage_word)
   );

   assign feed_load = (state_q == S_AACK) & scl_fall & rw_q & no_evt;
   assign feed_adv  = (state_q == S_RMACK) & scl_fall & ack_q & ~feed_last & no_evt;

   i2cw_read_feed #(.WORD_W(WORD_W)) u_feed (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (feed_load),
      .word_in  (reg_rd_data),
      .advance  (feed_adv),
      .cur_byte (feed_byte),
      .next_msb (feed_next_msb),
      .last     (feed_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         bitcnt_q    <= '0;
         shreg_q     <= '0;
         byte_full_q <= 1'b0;
         rw_q        <= 1'b0;
         ack_q       <= 1'b0;
         oe_q        <= 1'b0;
         idx_q       <= '0;
      end else if (start_det) begin
         state_q     <= S_ADDR;
         bitcnt_q    <= '0;
         byte_full_q <= 1'b0;
         oe_q        <= 1'b0;
      end else if (stop_det) begin
         state_q     <= S_IDLE;
         byte_full_q <= 1'b0;
         oe_q        <= 1'b0;
      end else begin
         if (stage_commit) begin
            idx_q <= idx_q + 1'b1;
         end
         unique case (state_q)
            S_ADDR, S_IDX, S_WDAT: begin
               if (scl_rise && !byte_full_q) begin
                  shreg_q  <= {shreg_q[6:0], sda_s};
                  bitcnt_q <= bitcnt_q + 1'b1;
                  if (bitcnt_q == 3'd7) begin
                     byte_full_q <= 1'b1;
                  end
               end else if (scl_fall && byte_full_q) begin
                  byte_full_q <= 1'b0;
                  if (state_q == S_ADDR) begin
                     if (addr_hit(shreg_q[7:1], ADDR_FIXED, addr_strap)) begin
                        rw_q    <= shreg_q[0];
                        oe_q    <= 1'b1;
                        state_q <= S_AACK;
                     end else begin
                        state_q <= S_IGNORE;
                     end
                  end else if (state_q == S_IDX) begin
                     idx_q   <= shreg_q[IDX_W-1:0];
                     oe_q    <= 1'b1;
                     state_q <= S_IACK;
                  end else begin
                     oe_q    <= 1'b1;
                     state_q <= S_WACK;
                  end
               end
            end
            S_AACK: begin
               if (scl_fall) begin
                  bitcnt_q <= '0;
                  if (rw_q) begin
                     oe_q    <= ~reg_rd_data[WORD_W-1];
                     state_q <= S_RDAT;
                  end else begin
                     oe_q    <= 1'b0;
                     state_q <= S_IDX;
                  end
               end
            end
            S_IACK, S_WACK: begin
               if (scl_fall) begin
                  oe_q     <= 1'b0;
                  bitcnt_q <= '0;
                  state_q  <= S_WDAT;
               end
            end
            S_RDAT: begin
               if (scl_rise) begin
                  bitcnt_q <= bitcnt_q + 1'b1;
                  if (bitcnt_q == 3'd7) begin
                     byte_full_q <= 1'b1;
                  end
               end else if (scl_fall) begin
                  if (byte_full_q) begin
                     byte_full_q <= 1'b0;
                     oe_q        <= 1'b0;
                     state_q     <= S_RMACK;
                  end else begin
                     oe_q <= ~feed_byte[3'd7 - bitcnt_q];
                  end
               end
            end
            S_RMACK: begin
               if (scl_rise) begin
                  ack_q <= ~sda_s;
               end else if (scl_fall) begin
                  if (ack_q && !feed_last) begin
                     oe_q     <= ~feed_next_msb;
                     bitcnt_q <= '0;
                     state_q  <= S_RDAT;
                  end else begin
                     state_q <= S_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe      = oe_q;
   assign reg_wr_en   = stage_commit;
   assign reg_wr_idx  = idx_q;
   assign reg_wr_data = stage_word;
   assign reg_rd_idx  = idx_q;

   a_r8_oe_moves_scl_low : assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

   a_r4_commit_during_ack : assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> sda_oe);

   a_r5_commit_only_in_ack : assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (state_q == S_WACK));

   a_r3_silent_when_unaddressed : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE || state_q == S_IGNORE) |-> !oe_q);

   a_r11_stop_releases : assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!oe_q && state_q == S_IDLE));

endmodule

// File: tb/i2cw_target_tb_top.sv
module i2cw_target_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_scl = 1'b1;
   logic host_sda = 1'b1;
   logic host_tx  = 1'b1;
   logic strap    = 1'b0;
   logic sda_oe, wr_en;
   logic [5:0]  wr_idx, rd_idx;
   logic [23:0] wr_data, rd_data;
   logic        sda_line;

   logic [23:0] regs  [0:63];
   logic [23:0] model [0:63];
   logic [29:0] exp_q [$];

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = host_sda & ~sda_oe;
   assign rd_data  = regs[rd_idx];

   i2cw_target dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (host_scl),
      .sda_i       (sda_line),
      .addr_strap  (strap),
      .sda_oe      (sda_oe),
      .reg_wr_en   (wr_en),
      .reg_wr_idx  (wr_idx),
      .reg_wr_data (wr_data),
      .reg_rd_idx  (rd_idx),
      .reg_rd_data (rd_data)
   );

   always @(posedge clk) begin
      if (wr_en) regs[wr_idx] <= wr_data;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Per-clock comparison against the reference model
   always @(negedge clk) begin
      if (rst_n) begin
         if (host_tx && sda_oe) begin
            failures++;
            $display("FAIL R8 drive while host owns SDA actual=1 expected=0");
         end
         if (wr_en) begin
            if (exp_q.size() == 0) begin
               failures++;
               $display("FAIL R5 unexpected write actual=%h expected=none", {wr_idx, wr_data});
            end else begin
               chk({wr_idx, wr_data} == exp_q[0], "R4", "write word",
                   {2'b0, wr_idx, wr_data}, {2'b0, exp_q[0]});
               model[exp_q[0][29:24]] = exp_q[0][23:0];
               void'(exp_q.pop_front());
            end
         end
      end
   end

   task automatic wait_q();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      host_tx = 1'b1;
      host_sda = 1'b1; wait_q();
      host_scl = 1'b1; wait_q();
      host_sda = 1'b0; wait_q();
      host_scl = 1'b0; host_tx = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; wait_q();
      host_tx = 1'b1;
      host_scl = 1'b1; wait_q();
      host_sda = 1'b1; wait_q(); wait_q();
   endtask

   task automatic wbit(input logic b);
      host_sda = b; wait_q();
      host_tx = 1'b1; host_scl = 1'b1; wait_q(); wait_q();
      host_scl = 1'b0; host_tx = 1'b0; wait_q();
   endtask

   task automatic rbit(output logic b);
      host_sda = 1'b1; wait_q();
      host_scl = 1'b1; wait_q();
      b = sda_line; wait_q();
      host_scl = 1'b0; wait_q();
   endtask

   task automatic wbyte(input logic [7:0] v, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(x);
      ack = ~x;
   endtask

   task automatic rbyte(input logic send_ack, output logic [7:0] v);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         rbit(x);
         v[i] = x;
      end
      wbit(~send_ack);
   endtask

   task automatic send(input logic [7:0] v, input logic exp_ack, input string req);
      logic a;
      wbyte(v, a);
      chk(a == exp_ack, req, $sformatf("ack for byte %h", v), {31'b0, a}, {31'b0, exp_ack});
   endtask

   task automatic write_word(input logic [5:0] idx, input logic [23:0] w);
      bus_start();
      send({6'b000100, strap, 1'b0}, 1'b1, "R2");
      send({2'b00, idx}, 1'b1, "R9");
      send(w[23:16], 1'b1, "R9");
      send(w[15:8], 1'b1, "R9");
      exp_q.push_back({idx, w});
      send(w[7:0], 1'b1, "R9");
      bus_stop();
   endtask

   task automatic read_word(input logic [5:0] idx, output logic [23:0] w);
      bus_start();
      send({6'b000100, strap, 1'b0}, 1'b1, "R2");
      send({2'b00, idx}, 1'b1, "R9");
      bus_start();
      send({6'b000100, strap, 1'b1}, 1'b1, "R2");
      rbyte(1'b1, w[23:16]);
      rbyte(1'b1, w[15:8]);
      rbyte(1'b0, w[7:0]);
      bus_stop();
   endtask

   task automatic expect_reg(input logic [5:0] idx, input string req);
      logic [23:0] w;
      read_word(idx, w);
      chk(w == model[idx], req, $sformatf("read of index %0d", idx), {8'b0, w}, {8'b0, model[idx]});
   endtask

   task automatic check_no_pending(input string req);
      chk(exp_q.size() == 0, req, "writes still pending", exp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [23:0] w;
      for (int i = 0; i < 64; i++) begin
         regs[i]  = 24'h0;
         model[i] = 24'h0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sda_oe == 1'b0, "R1", "sda_oe after reset", {31'b0, sda_oe}, 0);
      chk(wr_en == 1'b0, "R1", "wr_en after reset", {31'b0, wr_en}, 0);
      wait_q();

      // R4 basic write and R6 readback, strap low
      write_word(6'd5, 24'hA1B2C3);
      check_no_pending("R4");
      expect_reg(6'd5, "R6");
      write_word(6'd12, 24'h00FF5A);
      expect_reg(6'd12, "R6");

      // R2 wrong address with strap low
      bus_start();
      send(8'h12, 1'b0, "R2");
      bus_stop();

      // R2 strap high
      strap = 1'b1;
      wait_q();
      bus_start();
      send(8'h10, 1'b0, "R2");
      bus_stop();
      write_word(6'd20, 24'h135724);
      check_no_pending("R2");
      expect_reg(6'd20, "R6");
      strap = 1'b0;
      wait_q();

      // R3 general call and 10-bit header, then bytes that must be left alone
      bus_start();
      send(8'h00, 1'b0, "R3");
      send(8'h05, 1'b0, "R3");
      send(8'hAA, 1'b0, "R3");
      bus_stop();
      bus_start();
      send(8'hF0, 1'b0, "R3");
      send(8'h08, 1'b0, "R3");
      bus_stop();

      // R5 partial writes: zero, one and two data bytes then STOP
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'h05, 1'b1, "R9");
      bus_stop();
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'h05, 1'b1, "R9");
      send(8'h77, 1'b1, "R9");
      bus_stop();
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'h05, 1'b1, "R9");
      send(8'h77, 1'b1, "R9");
      send(8'h66, 1'b1, "R9");
      bus_stop();
      check_no_pending("R5");
      expect_reg(6'd5, "R5");

      // R5 repeated START after one byte, then a full word to same index
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'h09, 1'b1, "R9");
      send(8'h11, 1'b1, "R9");
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'h09, 1'b1, "R9");
      send(8'h22, 1'b1, "R9");
      send(8'h33, 1'b1, "R9");
      exp_q.push_back({6'd9, 24'h223344});
      send(8'h44, 1'b1, "R9");
      bus_stop();
      check_no_pending("R5");
      expect_reg(6'd9, "R5");

      // R10 two words from index 63 wrap to 0; index byte upper bits ignored (R4)
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'hFF, 1'b1, "R9");
      send(8'hDE, 1'b1, "R9");
      send(8'hAD, 1'b1, "R9");
      exp_q.push_back({6'd63, 24'hDEADBE});
      send(8'hBE, 1'b1, "R9");
      send(8'h01, 1'b1, "R9");
      send(8'h02, 1'b1, "R9");
      exp_q.push_back({6'd0, 24'h010203});
      send(8'h03, 1'b1, "R9");
      bus_stop();
      check_no_pending("R10");
      expect_reg(6'd63, "R10");
      expect_reg(6'd0, "R10");

      // R7 NACK after second read byte; host keeps clocking, bus must stay high
      bus_start();
      send(8'h10, 1'b1, "R2");
      send(8'h05, 1'b1, "R9");
      bus_start();
      send(8'h11, 1'b1, "R2");
      rbyte(1'b1, b);
      chk(b == model[5][23:16], "R6", "first read byte", {24'b0, b}, {24'b0, model[5][23:16]});
      rbyte(1'b0, b);
      chk(b == model[5][15:8], "R6", "second read byte", {24'b0, b}, {24'b0, model[5][15:8]});
      rbyte(1'b0, b);
      chk(b == 8'hFF, "R7", "bus after NACK", {24'b0, b}, 32'hFF);
      bus_stop();

      // R11 STOP in the middle of an address byte, then normal traffic
      bus_start();
      wbit(1'b0); wbit(1'b0); wbit(1'b0);
      bus_stop();
      @(negedge clk);
      chk(sda_oe == 1'b0, "R11", "released after STOP", {31'b0, sda_oe}, 0);
      write_word(6'd33, 24'h5A5A5A);
      check_no_pending("R11");
      read_word(6'd33, w);
      chk(w == 24'h5A5A5A, "R11", "traffic after aborted address", {8'b0, w}, 32'h5A5A5A);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule